// File: doc/BRIEF.md
# Dual-Issue Pair Steering

This block sits between instruction fetch and decode in a two-wide in-order machine. Each cycle it looks at a 64-bit fetch packet that holds two 32-bit instructions. It decides whether both instructions may leave together, only the first, or none. Only one pairing is allowed to issue together: an integer-class instruction (integer, load/store or branch) in the low slot, followed by a floating-point instruction in the high slot, in a packet whose fetch address is 64-bit aligned. In the best case this gives two instructions per cycle, a CPI of 0.5.

Any other packet is split. The low instruction leaves alone, and the block keeps the high instruction in a one-entry hold register. On the next cycle it sends the held instruction alone, before it takes another packet. A fetch address with bit 2 set marks a packet that carries only one instruction, in the low slot. That instruction issues alone, and the block does not look at the high word. Fetch and decode connect through valid/ready handshakes. When decode is not ready, nothing is consumed.

Top module: `dual_issue_steer`

## Requirements
- R1: After reset nothing is held. With no packet offered and nothing held, both issue valids are low and `pkt_ready_o` equals `dec_ready_i`.
- R2: An instruction is floating-point exactly when bits [31:26] equal 6'h11. Every other opcode, including nearby values such as 6'h10 and 6'h13, is integer-class.
- R3: Take an aligned packet with an integer-class instruction in bits [31:0] and a floating-point instruction in bits [63:32]. Both issue in the same cycle: lane 0 carries the low instruction, lane 1 carries the high one, and the packet is accepted in that cycle when decode is ready.
- R4: A packet with a floating-point instruction in the low slot and an integer-class instruction in the high slot does not dual-issue. The low instruction issues alone on lane 0.
- R5: Two integer-class instructions, or two floating-point instructions, never issue in the same cycle. The low one issues alone.
- R6: When `fetch_addr_b2_i` is 1, the low instruction issues alone. The high word is ignored and nothing is held.
- R7: After a split packet is accepted, the high instruction issues alone on lane 0 in the next cycle that has no stall. While it is held, `pkt_ready_o` is low.
- R8: While `dec_ready_i` is low, no instruction is consumed. A held instruction stays presented unchanged, and the packet is not accepted.
- R9: Lane 1 is valid only when lane 0 is valid. Zero, one or two instructions issue per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Fetch packet offered |
| pkt_ready_o | output | 1 | Packet accepted this cycle when valid |
| pkt_data_i | input | 64 | Low slot [31:0], high slot [63:32] |
| fetch_addr_b2_i | input | 1 | Bit 2 of the packet fetch address |
| iss0_valid_o | output | 1 | Lane 0 issues |
| iss0_instr_o | output | 32 | Lane 0 instruction (older) |
| iss1_valid_o | output | 1 | Lane 1 issues (floating-point partner) |
| iss1_instr_o | output | 32 | Lane 1 instruction |
| dec_ready_i | input | 1 | Decode can take this cycle's issue |

## Verification
Steering is combinational. Issue valids, lane contents and `pkt_ready_o` follow the packet and `dec_ready_i` in the same cycle. The only registered result is the held high instruction, which is due on lane 0 in the cycle after the clock edge that accepted the split packet. The bench drives inputs on the falling edge and samples all outputs 1 ns later. Its reference model updates its hold state only at the rising edge that commits the handshake, so every comparison refers to the right cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FP  = 1'b1
  } instr_cls_e;
endpackage

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
#(
  parameter int unsigned OPC_W = 6,
  parameter logic [OPC_W-1:0] FP_OPC = 6'h11
) (
  input  logic [OPC_W-1:0] opc_i,
  output instr_cls_e       cls_o
);
  assign cls_o = (opc_i == FP_OPC) ? CLS_FP : CLS_INT;
endmodule

// File: rtl/steer_pair_check.sv
module steer_pair_check
  import steer_pkg::*;
(
  input  instr_cls_e cls_lo_i,
  input  instr_cls_e cls_hi_i,
  input  logic       misalign_i,
  output logic       pair_ok_o
);
  // only aligned int-class then fp may leave together
  assign pair_ok_o = !misalign_i && (cls_lo_i == CLS_INT) && (cls_hi_i == CLS_FP);
endmodule

// File: rtl/steer_hold.sv
module steer_hold #(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               take_i,
  output logic               valid_o,
  output logic [INSTR_W-1:0] instr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      instr_o <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      instr_o <= instr_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !take_i) |=> (valid_o && $stable(instr_o)));

  assert_hold_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && take_i && !load_i) |=> !valid_o);

  assert_no_load_while_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !load_i);
endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import steer_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OPC_W   = 6,
  parameter logic [OPC_W-1:0] FP_OPC = 6'h11,
  localparam int unsigned NUM_SLOTS = 2,
  localparam int unsigned PKT_W = NUM_SLOTS * INSTR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_valid_i,
  output logic               pkt_ready_o,
  input  logic [PKT_W-1:0]   pkt_data_i,
  input  logic               fetch_addr_b2_i,
  output logic               iss0_valid_o,
  output logic [INSTR_W-1:0] iss0_instr_o,
  output logic               iss1_valid_o,
  output logic [INSTR_W-1:0] iss1_instr_o,
  input  logic               dec_ready_i
);
  logic [INSTR_W-1:0] slot_instr [NUM_SLOTS];
  instr_cls_e         slot_cls   [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_instr[g] = pkt_data_i[g*INSTR_W +: INSTR_W];
    steer_classify #(.OPC_W(OPC_W), .FP_OPC(FP_OPC)) i_cls (
      .opc_i (slot_instr[g][INSTR_W-1 -: OPC_W]),
      .cls_o (slot_cls[g])
    );
  end

  logic pair_ok;
  steer_pair_check i_pair (
    .cls_lo_i   (slot_cls[0]),
    .cls_hi_i   (slot_cls[1]),
    .misalign_i (fetch_addr_b2_i),
    .pair_ok_o  (pair_ok)
  );

  logic               hold_valid;
  logic [INSTR_W-1:0] hold_instr;
  logic               split_load;
  logic               hold_take;

  // split: aligned packet that cannot pair, accepted this cycle
  assign split_load = !hold_valid && pkt_valid_i && dec_ready_i && !pair_ok && !fetch_addr_b2_i;
  assign hold_take  = hold_valid && dec_ready_i;

  steer_hold #(.INSTR_W(INSTR_W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (split_load),
    .instr_i (slot_instr[1]),
    .take_i  (hold_take),
    .valid_o (hold_valid),
    .instr_o (hold_instr)
  );

  always_comb begin
    pkt_ready_o = !hold_valid && dec_ready_i;
    if (hold_valid) begin
      iss0_valid_o = 1'b1;
      iss0_instr_o = hold_instr;
      iss1_valid_o = 1'b0;
      iss1_instr_o = '0;
    end else begin
      iss0_valid_o = pkt_valid_i;
      iss0_instr_o = slot_instr[0];
      iss1_valid_o = pkt_valid_i && pair_ok;
      iss1_instr_o = iss1_valid_o ? slot_instr[1] : '0;
    end
  end

  assert_lane_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss1_valid_o |-> iss0_valid_o);

  assert_pair_classes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss1_valid_o |-> (iss0_instr_o[INSTR_W-1 -: OPC_W] != FP_OPC &&
                      iss1_instr_o[INSTR_W-1 -: OPC_W] == FP_OPC));

  assert_misalign_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && fetch_addr_b2_i) |-> !iss1_valid_o);

  assert_held_blocks_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_valid |-> (!pkt_ready_o && iss0_valid_o && !iss1_valid_o));

  assert_stall_no_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_ready_i |-> !pkt_ready_o);
endmodule

// File: tb/test_dual_issue_steer.sv
module test_dual_issue_steer;
  localparam logic [5:0] FP = 6'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [63:0] pkt_data = '0;
  logic        addr_b2 = 1'b0;
  logic        iss0_valid, iss1_valid;
  logic [31:0] iss0_instr, iss1_instr;
  logic        dec_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_hold = 1'b0;
  logic [31:0] m_hinstr = '0;

  always #4ns clk = ~clk;

  dual_issue_steer i_dual_issue_steer (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready),
    .pkt_data_i(pkt_data), .fetch_addr_b2_i(addr_b2),
    .iss0_valid_o(iss0_valid), .iss0_instr_o(iss0_instr),
    .iss1_valid_o(iss1_valid), .iss1_instr_o(iss1_instr),
    .dec_ready_i(dec_ready)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit fp);
    logic [5:0] o;
    o = 6'($urandom);
    if (fp) o = FP;
    else if (o == FP) o = 6'h12;
    return {o, 26'($urandom)};
  endfunction

  task automatic step(bit v, logic [63:0] d, bit odd, bit rdy);
    bit pair, e0v, e1v, erdy;
    logic [31:0] e0i;
    string tag;
    @(negedge clk);
    pkt_valid = v; pkt_data = d; addr_b2 = odd; dec_ready = rdy;
    #1ns;
    pair = !odd && d[31:26] != FP && d[63:58] == FP;
    erdy = !m_hold && rdy;
    if (m_hold) begin e0v = 1'b1; e0i = m_hinstr; e1v = 1'b0; end
    else begin e0v = v; e0i = d[31:0]; e1v = v && pair; end
    if (m_hold) tag = rdy ? "R7" : "R8";
    else if (!v) tag = "R1";
    else if (!rdy) tag = "R8";
    else if (odd) tag = "R6";
    else if (pair) tag = "R2 R3";
    else if (d[31:26] == FP && d[63:58] != FP) tag = "R2 R4";
    else tag = "R2 R5";
    chk(tag, "lane0 valid", 32'(iss0_valid), 32'(e0v));
    chk(tag, "lane1 valid", 32'(iss1_valid), 32'(e1v));
    chk(tag, "pkt_ready", 32'(pkt_ready), 32'(erdy));
    if (e0v) chk(tag, "lane0 instr", iss0_instr, e0i);
    if (e1v) chk(tag, "lane1 instr", iss1_instr, d[63:32]);
    chk("R9", "lane1 implies lane0", 32'(!iss1_valid || iss0_valid), 32'd1);
    if (m_hold) begin
      if (rdy) m_hold = 1'b0;
    end else if (v && rdy && !odd && !pair) begin
      m_hold = 1'b1;
      m_hinstr = d[63:32];
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] pd;
    bit pend, pv, po, pr, acc;
    // R1: reset state
    #3ns;
    chk("R1", "reset lane0 valid", 32'(iss0_valid), 32'd0);
    chk("R1", "reset lane1 valid", 32'(iss1_valid), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, 0, 1);
    // R3: int + fp aligned
    step(1, {mk(1), mk(0)}, 0, 1);
    // R2: near-FP opcodes are integer-class
    step(1, {FP, 26'h1, 6'h10, 26'h2}, 0, 1);
    step(1, {FP, 26'h3, 6'h13, 26'h4}, 0, 1);
    step(1, {6'h10, 26'h5, 6'h13, 26'h6}, 0, 1);
    step(1, {6'h33, 26'h7, 6'h20, 26'h8}, 0, 1);
    // R4 + R7: fp first, then held slot blocks a new packet
    step(1, {mk(0), mk(1)}, 0, 1);
    pd = {mk(1), mk(0)};
    step(1, pd, 0, 1);
    step(1, pd, 0, 1);
    // R5: int+int and fp+fp
    step(1, {mk(0), mk(0)}, 0, 1);
    step(0, '0, 0, 1);
    step(1, {mk(1), mk(1)}, 0, 1);
    step(0, '0, 0, 1);
    // R6: misaligned single, high word ignored
    step(1, {mk(1), mk(0)}, 1, 1);
    step(1, {mk(0), mk(0)}, 1, 1);
    step(0, '0, 0, 1);
    // R8: stall with packet, then with held slot
    pd = {mk(0), mk(0)};
    step(1, pd, 0, 0);
    step(1, pd, 0, 0);
    step(1, pd, 0, 1);
    step(0, '0, 0, 0);
    step(0, '0, 0, 0);
    step(0, '0, 0, 1);
    // random traffic with a compliant source
    pend = 1'b0; pd = '0; po = 1'b0; pv = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (!pend) begin
        pv = ($urandom % 4) != 0;
        pd = {mk(($urandom % 2) == 1), mk(($urandom % 2) == 1)};
        po = ($urandom % 6) == 0;
      end
      pr = ($urandom % 4) != 0;
      acc = pv && !m_hold && pr;
      step(pv, pd, po, pr);
      pend = pv && !acc;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule